// File: doc/BRIEF.md
# Descriptor-Chain Frame Extraction DMA

This block moves frames from a switch CPU queue into memory. Frames arrive as a byte stream with start and end markers. The block walks a linked chain of descriptors held in memory. Each descriptor occupies 64-bit slots. The first slot holds the link to the next descriptor. The second holds a control word. After those come per-block pairs: a buffer address slot followed by a status slot. Incoming bytes are packed into 64-bit words and written into the buffer of the current block. When a block ends, a single status word is written back.

Software prepares the chain and loads the start address as two 32-bit halves. It then pulses activate. When the channel meets a link whose bit 0 is set, it parks. Software can then append a descriptor, repair that link and pulse reload. A stop request lets the frame in progress complete and then reports that the channel holds no frame data. Memory is reached through a simple request/acknowledge word port.

Top module: `xdma_extract`

## Requirements
- R1: On `sw_activate` from the idle or halted state, the descriptor address becomes `{sw_ptr_hi, sw_ptr_lo}`. The channel reads the control word at descriptor+8, whose bits 15:0 give the per-block byte capacity. For each block b it then reads the buffer address at descriptor+16+16*b before filling that block.
- R2: Accepted bytes are packed little-endian, byte k of a word in bits 8k+7:8k, into 64-bit words. Each word is written to buffer address + word offset, and the offset starts at 0 for each block. A word is written when 8 bytes are held, or at a frame end or block end. Unused bytes of a partial word are zero. `in_ready` is never high while a memory request is open.
- R3: A block ends when it reaches its capacity or on the byte marked `in_eof`. A frame longer than the remaining capacity continues in the next block. Start-of-frame is set only in the status of the block that received the `in_sof` byte. End-of-frame is set only in the status of the block that received the `in_eof` byte.
- R4: Each block end produces one write of the status word to descriptor+24+16*b. The word is laid out as follows, and the upper 32 bits are zero:

  | Bits | Field |
  |------|-------|
  | 15:0 | bytes stored |
  | 16 | start-of-frame |
  | 17 | end-of-frame |
  | 18 | interrupt |
  | 19 | done, always 1 |
  | 31:20 | offset, always 0 |
- R5: After `sw_blocks` blocks, the channel reads the link at descriptor+0. If bit 0 of the link is clear, the link becomes the next descriptor. If bit 0 is set, the channel parks: it issues no memory request and `in_ready` stays low.
- R6: `sw_reload` in the parked state makes the channel re-read the link of the same descriptor and continue if that link is now valid. `sw_reload` in any other state has no effect.
- R7: With `sw_eof_only` low, every block raises the interrupt and sets status bit 18. With `sw_eof_only` high, only blocks carrying end-of-frame do so.
- R8: A raised interrupt sets a pending bit, and `irq` = pending AND `sw_irq_en`. A `sw_irq_clr` pulse clears the pending bit on the next cycle when no new block interrupt arrives in the same cycle.
- R9: `sw_stop` lets the current frame complete. The channel then halts: `buf_empty` is high, `in_ready` is low and no memory request is issued. A new `sw_activate` restarts the channel and clears `buf_empty`.
- R10: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`.
- R11: After reset, `mem_req`, `irq`, `in_ready` and `buf_empty` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_activate | input | 1 | Start the channel from the loaded list pointer |
| sw_reload | input | 1 | Re-read the parked link |
| sw_stop | input | 1 | Halt after the current frame |
| sw_ptr_lo | input | 32 | List pointer, low half |
| sw_ptr_hi | input | 32 | List pointer, high half |
| sw_blocks | input | CW | Blocks used per descriptor (1..MAX_DB) |
| sw_eof_only | input | 1 | Interrupt only on frame-ending blocks |
| sw_irq_en | input | 1 | Interrupt enable mask |
| sw_irq_clr | input | 1 | Write-1 clear of the pending bit |
| buf_empty | output | 1 | Channel halted, no frame data held |
| irq | output | 1 | Interrupt output |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte starts a frame |
| in_eof | input | 1 | Byte ends a frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The assertions assume the following about the inputs:
- `mem_ack` is only ever raised in answer to an open request, and it drops in the cycle after it completes one.
- Each frame begins with an `in_sof` byte, and the stream does not begin a new frame before the previous `in_eof`.
- The chain holds only capacities of at least one byte and block counts between one and the maximum.

The bench memory model acknowledges only a pending request and always idles for a cycle between acknowledges. The stimulus sends only whole, marked frames into descriptors whose capacity is 20 bytes, using two blocks per descriptor.

// File: rtl/xdma_pkg.sv
// Shared types for the extraction DMA: walker states and status word packing.
package xdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INFO,
        ST_DPTR,
        ST_FILL,
        ST_WDATA,
        ST_WSTAT,
        ST_NEXT,
        ST_PARK,
        ST_HALT
    } xdma_state_t;

    // Status layout: len 15:0, sof 16, eof 17, intr 18, done 19, offset 31:20
    function automatic logic [31:0] pack_status(input logic [15:0] len,
                                                input logic sof,
                                                input logic eof,
                                                input logic intr);
        return {12'd0, 1'b1, intr, eof, sof, len};
    endfunction

endpackage

// File: rtl/xdma_packer.sv
// Byte-to-word packer. Assembles bytes little-endian into one memory word and
// tracks the byte count and word offset inside the current block.
// Assumes take never coincides with word_done or blk_done.
module xdma_packer #(
    parameter int DW = 64,
    localparam int BPW = DW / 8,
    localparam int FW = $clog2(BPW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [7:0]    din,
    input  logic          word_done,
    input  logic          blk_done,
    output logic [DW-1:0] word,
    output logic [FW-1:0] fill,
    output logic [15:0]   blk_bytes,
    output logic [15:0]   word_off
);

    // Collect bytes, clear the word after its write, rewind at block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word      <= '0;
            fill      <= '0;
            blk_bytes <= '0;
            word_off  <= '0;
        end else if (take) begin
            word[{fill, 3'b000} +: 8] <= din;
            fill                      <= fill + 1'b1;
            blk_bytes                 <= blk_bytes + 16'd1;
        end else if (word_done) begin
            word     <= '0;
            fill     <= '0;
            word_off <= word_off + 16'(BPW);
        end else if (blk_done) begin
            blk_bytes <= '0;
            word_off  <= '0;
        end
    end

endmodule

// File: rtl/xdma_irq.sv
// Pending interrupt bit with write-1 clear and an enable mask.
// Assumes a raise and a clear in the same cycle should leave the bit set.
module xdma_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    input  logic en,
    output logic irq
);

    logic pending;

    // Hold pending until cleared; a new raise takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (raise)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

    assign irq = pending & en;

endmodule

// File: rtl/xdma_walker.sv
// Descriptor walker: fetches control word, buffer pointers and links, steers
// the stream into the packer, writes data words and status, parks on an
// invalid link and halts on a stop request between frames.
// Assumes block capacity >= 1 and 1 <= blocks <= maximum.
module xdma_walker
    import xdma_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 64,
    parameter int CW = 3,
    localparam int FW = $clog2(DW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          activate,
    input  logic          reload,
    input  logic          stop_req,
    input  logic [AW-1:0] list_ptr,
    input  logic [CW-1:0] blocks,
    input  logic          eof_only,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          in_ready,
    output logic          take,
    input  logic [DW-1:0] word,
    input  logic [FW-1:0] fill,
    input  logic [15:0]   blk_bytes,
    input  logic [15:0]   word_off,
    output logic          word_done,
    output logic          blk_done,
    output logic          raise,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          buf_empty,
    output xdma_state_t   state
);

    logic [AW-1:0] desc, dptr;
    logic [15:0]   blk_len;
    logic [CW-1:0] blk;
    logic          blk_sof, last_eof, blk_end, frm_act, stop_pend;
    logic          halt_now, end_here, intr_here;
    logic [AW-1:0] slot;

    assign slot      = AW'(blk) << 4;
    assign halt_now  = stop_pend && !frm_act;
    assign in_ready  = (state == ST_FILL) && !halt_now;
    assign take      = in_valid && in_ready;
    assign end_here  = in_eof || (blk_bytes + 16'd1 == blk_len);
    assign intr_here = !eof_only || last_eof;
    assign word_done = (state == ST_WDATA) && mem_ack;
    assign blk_done  = (state == ST_WSTAT) && mem_ack;
    assign raise     = blk_done && intr_here;
    assign buf_empty = (state == ST_HALT);

    // Memory request decode per state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = desc;
        mem_wdata = '0;
        case (state)
            ST_NEXT:  mem_addr = desc;
            ST_INFO:  mem_addr = desc + AW'(8);
            ST_DPTR:  mem_addr = desc + AW'(16) + slot;
            ST_WDATA: begin
                mem_we    = 1'b1;
                mem_addr  = dptr + AW'(word_off);
                mem_wdata = word;
            end
            ST_WSTAT: begin
                mem_we    = 1'b1;
                mem_addr  = desc + AW'(24) + slot;
                mem_wdata = DW'(pack_status(blk_bytes, blk_sof, last_eof, intr_here));
            end
            default:  mem_req = 1'b0;
        endcase
    end

    // Channel sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            desc      <= '0;
            dptr      <= '0;
            blk_len   <= '0;
            blk       <= '0;
            blk_sof   <= 1'b0;
            last_eof  <= 1'b0;
            blk_end   <= 1'b0;
            frm_act   <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (stop_req)
                stop_pend <= 1'b1;
            case (state)
                ST_IDLE, ST_HALT: if (activate) begin
                    desc      <= list_ptr;
                    blk       <= '0;
                    blk_sof   <= 1'b0;
                    last_eof  <= 1'b0;
                    frm_act   <= 1'b0;
                    stop_pend <= 1'b0;
                    state     <= ST_INFO;
                end
                ST_INFO: if (mem_ack) begin
                    blk_len <= mem_rdata[15:0];
                    state   <= ST_DPTR;
                end
                ST_DPTR: if (mem_ack) begin
                    dptr  <= mem_rdata[AW-1:0];
                    state <= ST_FILL;
                end
                ST_FILL: if (halt_now) begin
                    stop_pend <= 1'b0;
                    state     <= ST_HALT;
                end else if (take) begin
                    if (in_sof)
                        blk_sof <= 1'b1;
                    frm_act  <= !in_eof;
                    last_eof <= in_eof;
                    blk_end  <= end_here;
                    if (end_here || (fill == FW'(DW / 8 - 1)))
                        state <= ST_WDATA;
                end
                ST_WDATA: if (mem_ack)
                    state <= blk_end ? ST_WSTAT : ST_FILL;
                ST_WSTAT: if (mem_ack) begin
                    blk_sof  <= 1'b0;
                    last_eof <= 1'b0;
                    if (blk + 1'b1 == blocks) begin
                        blk   <= '0;
                        state <= ST_NEXT;
                    end else begin
                        blk   <= blk + 1'b1;
                        state <= ST_DPTR;
                    end
                end
                ST_NEXT: if (mem_ack) begin
                    if (mem_rdata[0])
                        state <= ST_PARK;
                    else begin
                        desc  <= mem_rdata[AW-1:0];
                        state <= ST_INFO;
                    end
                end
                ST_PARK: if (stop_pend) begin
                    stop_pend <= 1'b0;
                    state     <= ST_HALT;
                end else if (reload)
                    state <= ST_NEXT;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xdma_extract.sv
// Top of the extraction DMA: list-pointer assembly, walker, packer and
// interrupt unit. Assumes a memory port that acknowledges each request once.
module xdma_extract
    import xdma_pkg::*;
#(
    parameter int MAX_DB = 4,
    localparam int CW = $clog2(MAX_DB + 1),
    localparam int AW = 64,
    localparam int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_activate,
    input  logic          sw_reload,
    input  logic          sw_stop,
    input  logic [31:0]   sw_ptr_lo,
    input  logic [31:0]   sw_ptr_hi,
    input  logic [CW-1:0] sw_blocks,
    input  logic          sw_eof_only,
    input  logic          sw_irq_en,
    input  logic          sw_irq_clr,
    output logic          buf_empty,
    output logic          irq,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int FW = $clog2(DW / 8);

    logic          take, word_done, blk_done, raise;
    logic [DW-1:0] word;
    logic [FW-1:0] fill;
    logic [15:0]   blk_bytes, word_off;
    xdma_state_t   walk_state;

    xdma_walker #(.AW(AW), .DW(DW), .CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .activate(sw_activate), .reload(sw_reload), .stop_req(sw_stop),
        .list_ptr({sw_ptr_hi, sw_ptr_lo}), .blocks(sw_blocks),
        .eof_only(sw_eof_only),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .take(take),
        .word(word), .fill(fill), .blk_bytes(blk_bytes), .word_off(word_off),
        .word_done(word_done), .blk_done(blk_done), .raise(raise),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_empty(buf_empty), .state(walk_state)
    );

    xdma_packer #(.DW(DW)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .take(take), .din(in_data),
        .word_done(word_done), .blk_done(blk_done),
        .word(word), .fill(fill), .blk_bytes(blk_bytes), .word_off(word_off)
    );

    xdma_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .raise(raise), .clr(sw_irq_clr), .en(sw_irq_en), .irq(irq)
    );

endmodule

// File: rtl/xdma_extract_chk.sv
// Protocol and behaviour checks for the extraction DMA, bound to its top.
module xdma_extract_chk
    import xdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sw_reload,
    input logic        sw_irq_clr,
    input logic        sw_eof_only,
    input logic        buf_empty,
    input logic        irq,
    input logic        in_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_ack,
    input xdma_state_t st
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

    AST_NO_TAKE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req); // R2

    AST_STATUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && st == ST_WSTAT |-> mem_wdata[19] && mem_wdata[63:20] == '0); // R4

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_PARK && !sw_reload |=> !mem_req && !in_ready); // R5

    AST_EOF_ONLY_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && st == ST_WSTAT && sw_eof_only && !mem_wdata[17] |-> !mem_wdata[18]); // R7

    AST_CLR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        sw_irq_clr && !(st == ST_WSTAT && mem_ack) |=> !irq); // R8

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !in_ready && !mem_req); // R9

endmodule

bind xdma_extract xdma_extract_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_reload(sw_reload), .sw_irq_clr(sw_irq_clr),
    .sw_eof_only(sw_eof_only), .buf_empty(buf_empty), .irq(irq),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .st(walk_state)
);

// File: tb/sim_xdma_extract.sv
module sim_xdma_extract;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_activate = 1'b0, sw_reload = 1'b0, sw_stop = 1'b0;
    logic [31:0] sw_ptr_lo = '0, sw_ptr_hi = '0;
    logic [2:0]  sw_blocks = 3'd2;
    logic        sw_eof_only = 1'b0, sw_irq_en = 1'b1, sw_irq_clr = 1'b0;
    logic        buf_empty, irq;
    logic        in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int req_seen = 0;

    logic [63:0]  mem [0:511];
    logic [127:0] sb_q [$];

    // Bench model state
    logic [63:0] m_next [0:3];
    logic [15:0] m_len  [0:3];
    logic [63:0] m_base;
    int          m_b;
    logic        m_eof_only;
    logic        m_irq;

    always #2.5 clk = ~clk;

    xdma_extract u0 (
        .clk(clk), .rst_n(rst_n), .sw_activate(sw_activate), .sw_reload(sw_reload),
        .sw_stop(sw_stop), .sw_ptr_lo(sw_ptr_lo), .sw_ptr_hi(sw_ptr_hi),
        .sw_blocks(sw_blocks), .sw_eof_only(sw_eof_only), .sw_irq_en(sw_irq_en),
        .sw_irq_clr(sw_irq_clr), .buf_empty(buf_empty), .irq(irq),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledge a pending request one cycle later
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:3]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every completed write is compared with the model
    always @(negedge clk) begin
        if (rst_n && mem_req) req_seen++;
        if (rst_n && mem_req && mem_we && mem_ack) begin
            if (sb_q.size() == 0)
                chk(1'b0, "R2/R4 unexpected write", {mem_addr, mem_wdata}, '0);
            else begin
                logic [127:0] e;
                e = sb_q.pop_front();
                chk({mem_addr, mem_wdata} == e, "R2/R3/R4 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    function automatic logic [63:0] dptr_of(input logic [63:0] base, input int b);
        return 64'h400 + 64'(((base[7:6] * 2) + b) * 64);
    endfunction

    // Driver model: push the writes a frame must produce
    task automatic model_frame(input int n, input logic [7:0] seed);
        logic [63:0] w = '0;
        int fill = 0, bytes = 0, off = 0;
        logic bsof = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic is_eof, bend, intr;
            is_eof = (i == n - 1);
            w[fill*8 +: 8] = seed + 8'(i);
            fill++; bytes++;
            if (i == 0) bsof = 1'b1;
            bend = is_eof || (bytes == int'(m_len[m_base[7:6]]));
            if (fill == 8 || bend) begin
                sb_q.push_back({dptr_of(m_base, m_b) + 64'(off), w});
                w = '0; fill = 0; off += 8;
            end
            if (bend) begin
                intr = !m_eof_only || is_eof;
                if (intr) m_irq = 1'b1;
                sb_q.push_back({m_base + 64'(24 + 16 * m_b),
                                {32'd0, 12'd0, 1'b1, intr, is_eof, bsof, 16'(bytes)}});
                bytes = 0; off = 0; bsof = 1'b0;
                m_b++;
                if (m_b == 2) begin
                    m_b = 0;
                    if (!m_next[m_base[7:6]][0]) m_base = m_next[m_base[7:6]];
                end
            end
        end
    endtask

    task automatic drive_frame(input int n, input logic [7:0] seed, input int stop_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 8'(i);
            in_sof = (i == 0); in_eof = (i == n - 1);
            sw_stop = (i == stop_at);
            while (!in_ready) begin
                @(negedge clk);
                sw_stop = 1'b0;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; sw_stop = 1'b0;
    endtask

    task automatic send(input int n, input logic [7:0] seed, input int stop_at);
        model_frame(n, seed);
        drive_frame(n, seed, stop_at);
        for (int k = 0; k < 200 && sb_q.size() != 0; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(sb_q.size() == 0, "R2 all writes seen", 128'(sb_q.size()), 0);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic fill_mem;
        for (int d = 0; d < 3; d++) begin
            mem[d*8]     = m_next[d];
            mem[d*8 + 1] = 64'(m_len[d]);
            for (int b = 0; b < 2; b++)
                mem[d*8 + 2 + 2*b] = dptr_of(64'(d * 64), b);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        m_next[0] = 64'h40; m_next[1] = 64'h80; m_next[2] = 64'h1; m_next[3] = 64'h1;
        for (int d = 0; d < 4; d++) m_len[d] = 16'd20;
        fill_mem();
        m_base = 0; m_b = 0; m_eof_only = 1'b0; m_irq = 1'b0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!mem_req, "R11 mem_req", 128'(mem_req), 0);
        chk(!irq, "R11 irq", 128'(irq), 0);
        chk(!in_ready, "R11 in_ready", 128'(in_ready), 0);
        chk(!buf_empty, "R11 buf_empty", 128'(buf_empty), 0);

        // R1 activation; frame with partial word (R2), every-block interrupt (R7)
        pulse(sw_activate);
        send(12, 8'h10, -1);
        chk(irq == 1'b1, "R7/R8 irq after frame", 128'(irq), 1);
        pulse(sw_irq_clr);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq cleared", 128'(irq), 0);

        // R3 spill across descriptors (R5 link follow)
        send(30, 8'h40, -1);
        pulse(sw_irq_clr);

        // R6 reload while running is ignored; R7 eof-only; R8 mask
        sw_eof_only = 1'b1; m_eof_only = 1'b1;
        sw_irq_en = 1'b0;
        pulse(sw_reload);
        m_irq = 1'b0;
        send(25, 8'h80, -1);
        chk(irq == 1'b0, "R8 masked irq", 128'(irq), 0);
        @(negedge clk); sw_irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 unmasked irq", 128'(irq), 1);
        pulse(sw_irq_clr);
        @(negedge clk);

        // R5 chain end parks the channel
        send(20, 8'hA0, -1);
        repeat (5) @(negedge clk);
        req_seen = 0;
        repeat (40) @(negedge clk);
        chk(req_seen == 0, "R5 parked no requests", 128'(req_seen), 0);
        chk(!in_ready, "R5 parked not ready", 128'(in_ready), 0);

        // R6 reload after repairing the link
        m_next[2] = 64'h0; mem[16] = 64'h0;
        m_base = 64'h0; m_b = 0;
        pulse(sw_reload);
        send(9, 8'hC0, -1);

        // R9 stop mid-frame completes the frame then halts
        send(16, 8'hD0, 3);
        repeat (20) @(negedge clk);
        chk(buf_empty == 1'b1, "R9 buf_empty after stop", 128'(buf_empty), 1);
        chk(!in_ready, "R9 not ready when halted", 128'(in_ready), 0);

        // R1 restart with a high pointer half
        sw_ptr_hi = 32'h1; sw_ptr_lo = 32'h40;
        m_base = 64'h1_0000_0040; m_b = 0;
        pulse(sw_activate);
        @(negedge clk);
        chk(!buf_empty, "R9 activate clears halt", 128'(buf_empty), 0);
        send(4, 8'hE0, -1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule